// File: doc/BRIEF.md
# Page Write Staging Buffer with Timed Programming Sequencer

This block sits between a serial-bus slave controller and a small byte-wide storage array. During a bus write, the controller first hands over a starting byte address. It then streams data bytes. The block stages each byte into a one-page buffer of 2^COL_W slots, at the column named by the low address bits. Only those column bits advance after each byte, so the page never changes. When a long burst runs past the end of the page, it wraps to the start of the same page and overwrites bytes that were loaded earlier in the burst.

When the controller signals the end of the write, the block enters a self-timed programming window of WR_CYCLES clock cycles and holds a busy flag for that whole window. At the last cycle of the window, only the slots that were actually loaded are copied into the addressed page. Every other byte keeps its old value. While busy, every control strobe from the controller is ignored.

A write-protect input blocks programming entirely. An abort strobe throws away whatever has been staged. The array can be read at any time through a read port that is independent of busy and write protect. After programming, the controller reads back the internal address counter, which points one past the last byte written, wrapped within the page.

Top module: `pgbuf_prog`

## Requirements
- R1: After reset, busy is 0, next_addr is 0x00, and every array byte reads 0x00.
- R2: An accepted load_go sets next_addr to load_addr on the next clock and clears all slot valid bits. If load_go is repeated before any byte is staged, nothing is committed.
- R3: Each accepted wr_vld stores wr_data in the slot at column next_addr[COL_W-1:0] and marks that slot valid. Then the column increments modulo 2^COL_W, and next_addr[ADDR_W-1:COL_W] (the page) stays unchanged.
- R4: When more than 2^COL_W bytes are loaded, byte k+16 (with COL_W=4) lands in the same column as byte k and replaces it.
- R5: An accepted commit_go with at least one valid slot and wp_in low raises busy on the next clock edge. Busy then stays high for exactly WR_CYCLES cycles and falls. The array is updated on the edge where busy falls.
- R6: Programming writes only the valid slots, into the page given by next_addr[ADDR_W-1:COL_W]. Every other array byte, inside or outside that page, keeps its value.
- R7: While busy is 1, load_go, wr_vld, commit_go and abort_go have no effect. The address counter and the staged data stay as they were, and no new programming starts. Valid bits are cleared when programming ends.
- R8: An accepted commit_go while wp_in is 1 leaves the array unchanged, does not raise busy, and discards the staged bytes.
- R9: An accepted abort_go clears all valid bits. A commit_go with no valid slot neither raises busy nor changes the array. When strobes arrive together, the priority is abort_go, then load_go, then commit_go, then wr_vld.
- R10: With READ_REG=0, rd_data shows array[rd_addr] combinationally, whatever wp_in and busy are. During the busy window it shows the contents from before the commit.
- R11: After programming, next_addr equals the last written address plus one, wrapped within the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_go | input | 1 | Start of a write: load the address counter |
| load_addr | input | ADDR_W | Starting byte address |
| wr_vld | input | 1 | Data byte strobe |
| wr_data | input | DATA_W | Data byte |
| commit_go | input | 1 | End of write: begin programming |
| abort_go | input | 1 | Discard staged bytes |
| wp_in | input | 1 | Write protect, active high |
| busy | output | 1 | Programming window in progress |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array byte at rd_addr |
| next_addr | output | ADDR_W | Internal address counter |

## Verification
The bench builds the block with WR_CYCLES=6 and READ_REG=0 and keeps the default 8-bit address with 16-byte pages. The short window lets the bench count the busy length exactly and still issue reads and rejected strobes inside the window. It also lets the bench run 18-byte bursts that overwrite earlier bytes, single-byte partial pages, write-protected commits and aborted writes, and check the result against a byte-level model of the whole 256-byte array.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
   typedef enum logic {
      PG_IDLE = 1'b0,
      PG_PROG = 1'b1
   } pg_state_e;
endpackage

// File: rtl/pgbuf_stage.sv
module pgbuf_stage #(
   parameter int ADDR_W = 8,
   parameter int COL_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                do_load,
   input  logic [ADDR_W-1:0]                   load_addr,
   input  logic                                do_byte,
   input  logic [DATA_W-1:0]                   byte_data,
   input  logic                                flush,
   output logic [ADDR_W-1:0]                   ptr,
   output logic [(1<<COL_W)-1:0][DATA_W-1:0]   slot_data,
   output logic [(1<<COL_W)-1:0]               slot_vld,
   output logic                                any_vld
);
   localparam int SLOTS = 1 << COL_W;

   logic [COL_W-1:0] col;
   assign col = ptr[COL_W-1:0];

   // address counter: only the column field moves on a data byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (do_load) begin
         ptr <= load_addr;
      end else if (do_byte) begin
         ptr <= {ptr[ADDR_W-1:COL_W], col + COL_W'(1)};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_vld  <= '0;
         slot_data <= '0;
      end else begin
         for (int c = 0; c < SLOTS; c++) begin
            if (flush || do_load) begin
               slot_vld[c] <= 1'b0;
            end else if (do_byte && (col == COL_W'(c))) begin
               slot_vld[c]  <= 1'b1;
               slot_data[c] <= byte_data;
            end
         end
      end
   end

   assign any_vld = |slot_vld;
endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer
   import pgbuf_pkg::*;
#(
   parameter int WR_CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CNT_W = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES + 1);

   pg_state_e        state;
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= PG_IDLE;
         remain <= '0;
      end else begin
         case (state)
            PG_IDLE: begin
               if (start) begin
                  state  <= PG_PROG;
                  remain <= CNT_W'(WR_CYCLES - 1);
               end
            end
            PG_PROG: begin
               if (remain == '0) begin
                  state <= PG_IDLE;
               end else begin
                  remain <= remain - CNT_W'(1);
               end
            end
            default: state <= PG_IDLE;
         endcase
      end
   end

   assign busy = (state == PG_PROG);
   assign done = busy && (remain == '0);
endmodule

// File: rtl/pgbuf_array.sv
module pgbuf_array #(
   parameter int ADDR_W   = 8,
   parameter int COL_W    = 4,
   parameter int DATA_W   = 8,
   parameter int READ_REG = 0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [ADDR_W-COL_W-1:0]             wr_row,
   input  logic [(1<<COL_W)-1:0][DATA_W-1:0]   slot_data,
   input  logic [(1<<COL_W)-1:0]               slot_vld,
   input  logic [ADDR_W-1:0]                   rd_addr,
   output logic [DATA_W-1:0]                   rd_data
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int SLOTS = 1 << COL_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         for (int c = 0; c < SLOTS; c++) begin
            if (slot_vld[c]) mem[{wr_row, COL_W'(c)}] <= slot_data[c];
         end
      end
   end

   generate
      if (READ_REG != 0) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= mem[rd_addr];
         end
         assign rd_data = rd_q;
      end else begin : g_rd_comb
         assign rd_data = mem[rd_addr];
      end
   endgenerate
endmodule

// File: rtl/pgbuf_prog.sv
module pgbuf_prog #(
   parameter int ADDR_W    = 8,
   parameter int COL_W     = 4,
   parameter int DATA_W    = 8,
   parameter int WR_CYCLES = 250000,
   parameter int READ_REG  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_go,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              wr_vld,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit_go,
   input  logic              abort_go,
   input  logic              wp_in,
   output logic              busy,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] next_addr
);
   localparam int SLOTS = 1 << COL_W;
   localparam int ROW_W = ADDR_W - COL_W;

   generate
      if (COL_W < 1 || COL_W >= ADDR_W) begin : g_bad_col
         $error("pgbuf_prog: COL_W must lie in 1..ADDR_W-1");
      end
      if (WR_CYCLES < 1) begin : g_bad_wr
         $error("pgbuf_prog: WR_CYCLES must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("pgbuf_prog: DATA_W must be at least 1");
      end
   endgenerate

   logic                              prog_done, prog_start, any_vld, flush;
   logic                              do_abort, do_load, do_commit, do_byte;
   logic [ADDR_W-1:0]                 ptr;
   logic [SLOTS-1:0][DATA_W-1:0]      slot_data;
   logic [SLOTS-1:0]                  slot_vld;

   // fixed priority among strobes, all gated while programming
   assign do_abort  = !busy && abort_go;
   assign do_load   = !busy && !abort_go && load_go;
   assign do_commit = !busy && !abort_go && !load_go && commit_go;
   assign do_byte   = !busy && !abort_go && !load_go && !commit_go && wr_vld;

   assign prog_start = do_commit && !wp_in && any_vld;
   assign flush      = prog_done || do_abort || (do_commit && !prog_start);

   pgbuf_stage #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)) i_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .do_load   (do_load),
      .load_addr (load_addr),
      .do_byte   (do_byte),
      .byte_data (wr_data),
      .flush     (flush),
      .ptr       (ptr),
      .slot_data (slot_data),
      .slot_vld  (slot_vld),
      .any_vld   (any_vld)
   );

   pgbuf_timer #(.WR_CYCLES(WR_CYCLES)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (prog_start),
      .busy  (busy),
      .done  (prog_done)
   );

   pgbuf_array #(
      .ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W), .READ_REG(READ_REG)
   ) i_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (prog_done),
      .wr_row    (ptr[ADDR_W-1:ADDR_W-ROW_W]),
      .slot_data (slot_data),
      .slot_vld  (slot_vld),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );

   assign next_addr = ptr;
endmodule

// File: rtl/pgbuf_prog_chk.sv
module pgbuf_prog_chk #(
   parameter int ADDR_W    = 8,
   parameter int COL_W     = 4,
   parameter int WR_CYCLES = 250000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_go,
   input logic [ADDR_W-1:0] load_addr,
   input logic              wr_vld,
   input logic              commit_go,
   input logic              abort_go,
   input logic              wp_in,
   input logic              busy,
   input logic [ADDR_W-1:0] next_addr
);
   logic [31:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 32'd1;
      else           run_cnt <= '0;
   end

   // R5
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(commit_go) && !$past(wp_in) && !$past(abort_go)));

   // R5
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt < 32'(WR_CYCLES)));

   // R5
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(run_cnt) == 32'(WR_CYCLES - 1)));

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(next_addr));

   // R8
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && commit_go && !abort_go && !load_go && wp_in) |=> !busy);

   // R3
   page_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_vld && !abort_go && !load_go && !commit_go) |=>
         ((next_addr[ADDR_W-1:COL_W] == $past(next_addr[ADDR_W-1:COL_W])) &&
          (next_addr[COL_W-1:0] == COL_W'($past(next_addr[COL_W-1:0]) + 1'b1))));

   // R2
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && load_go && !abort_go) |=> (next_addr == $past(load_addr)));
endmodule

bind pgbuf_prog pgbuf_prog_chk #(
   .ADDR_W(ADDR_W), .COL_W(COL_W), .WR_CYCLES(WR_CYCLES)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_go   (load_go),
   .load_addr (load_addr),
   .wr_vld    (wr_vld),
   .commit_go (commit_go),
   .abort_go  (abort_go),
   .wp_in     (wp_in),
   .busy      (busy),
   .next_addr (next_addr)
);

// File: tb/test_pgbuf_prog.sv
module test_pgbuf_prog;
   localparam int WR = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_go = 1'b0, wr_vld = 1'b0, commit_go = 1'b0, abort_go = 1'b0, wp_in = 1'b0;
   logic [7:0] load_addr = '0, wr_data = '0, rd_addr = '0;
   logic       busy;
   logic [7:0] rd_data, next_addr;

   int n_cmp = 0;
   int n_bad = 0;

   logic [7:0] model [256];
   logic [7:0] q_addr [$];
   logic [7:0] q_data [$];
   string      q_req  [$];

   always #10 clk = ~clk;

   pgbuf_prog #(.WR_CYCLES(WR), .READ_REG(0)) i_pgbuf_prog (
      .clk(clk), .rst_n(rst_n), .load_go(load_go), .load_addr(load_addr),
      .wr_vld(wr_vld), .wr_data(wr_data), .commit_go(commit_go),
      .abort_go(abort_go), .wp_in(wp_in), .busy(busy), .rd_addr(rd_addr),
      .rd_data(rd_data), .next_addr(next_addr)
   );

   task automatic check(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // scoreboard monitor: one expected read per falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (q_addr.size() > 0) begin
            rd_addr = q_addr[0];
            #2;
            check($sformatf("%s rd[%0h]", q_req[0], q_addr[0]), rd_data, q_data[0]);
            void'(q_addr.pop_front());
            void'(q_data.pop_front());
            void'(q_req.pop_front());
         end
      end
   end

   task automatic expect_rd(logic [7:0] a, logic [7:0] d, string req);
      q_addr.push_back(a);
      q_data.push_back(d);
      q_req.push_back(req);
   endtask

   task automatic drain();
      while (q_addr.size() > 0) @(posedge clk);
   endtask

   task automatic verify_page(int row, string req);
      for (int c = 0; c < 16; c++) begin
         expect_rd(8'(row * 16 + c), model[row * 16 + c], req);
      end
      drain();
   endtask

   task automatic do_load(logic [7:0] a);
      @(negedge clk); load_go = 1'b1; load_addr = a;
      @(negedge clk); load_go = 1'b0;
   endtask

   task automatic send_bytes(int n, logic [7:0] base);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); wr_vld = 1'b1; wr_data = 8'(base + i);
      end
      @(negedge clk); wr_vld = 1'b0;
   endtask

   task automatic wait_busy(string req);
      int cnt = 1;
      forever begin
         @(negedge clk);
         if (!busy) break;
         cnt++;
      end
      check({req, " busy length"}, cnt, WR);
   endtask

   task automatic commit(logic exp_busy, string req);
      @(negedge clk); commit_go = 1'b1;
      @(negedge clk); commit_go = 1'b0;
      check({req, " busy after commit"}, busy, exp_busy);
      if (busy) wait_busy(req);
   endtask

   task automatic page_write(logic [7:0] start, int n, logic [7:0] base, logic wpv,
                             string req);
      logic [7:0] last;
      wp_in = wpv;
      do_load(start);
      send_bytes(n, base);
      check({req, " R3 counter after bytes"}, next_addr,
            {start[7:4], 4'(start[3:0] + n)});
      commit(!wpv, req);
      wp_in = 1'b0;
      if (!wpv) begin
         for (int i = 0; i < n; i++) begin
            last = {start[7:4], 4'(start[3:0] + i)};
            model[last] = 8'(base + i);
         end
         check({req, " R11 counter after commit"}, next_addr,
               {start[7:4], 4'(start[3:0] + n)});
      end
      verify_page(start[7:4], req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check("watchdog expired", 1, 0);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy at reset", busy, 0);
      check("R1 counter at reset", next_addr, 0);
      expect_rd(8'h00, 8'h00, "R1");
      expect_rd(8'h35, 8'h00, "R1");
      expect_rd(8'hFF, 8'h00, "R1");
      drain();

      // single byte
      page_write(8'h12, 1, 8'hA5, 1'b0, "R5 byte write");
      // four bytes wrapping past column 15
      page_write(8'h2E, 4, 8'h30, 1'b0, "R3 wrap in page");
      // eighteen bytes: last two overwrite first two columns
      page_write(8'h43, 18, 8'h10, 1'b0, "R4 overflow");
      expect_rd(8'h43, 8'h20, "R4 17th over 1st");
      expect_rd(8'h44, 8'h21, "R4 18th over 2nd");
      drain();
      // partial page: neighbours keep their values
      page_write(8'h2F, 1, 8'h77, 1'b0, "R6 partial");
      expect_rd(8'h2E, 8'h30, "R6 untouched neighbour");
      drain();
      // write protected
      page_write(8'h50, 3, 8'h99, 1'b1, "R8 protect");

      // abort before data, and repeated start before data
      do_load(8'h60);
      @(negedge clk); abort_go = 1'b1;
      @(negedge clk); abort_go = 1'b0;
      commit(1'b0, "R9 abort empty");
      do_load(8'h61);
      do_load(8'h62);
      check("R2 reload counter", next_addr, 8'h62);
      commit(1'b0, "R2 repeated start");
      verify_page(6, "R9 page 6");

      // abort after staged data
      do_load(8'h70);
      send_bytes(2, 8'h55);
      @(negedge clk); abort_go = 1'b1;
      @(negedge clk); abort_go = 1'b0;
      commit(1'b0, "R9 abort staged");
      verify_page(7, "R9 page 7");

      // strobes during busy are ignored; reads show old data
      do_load(8'h80);
      send_bytes(2, 8'hC1);
      @(negedge clk); commit_go = 1'b1;
      @(negedge clk);
      check("R5 busy after commit", busy, 1);
      load_go = 1'b1; load_addr = 8'h90; wr_vld = 1'b1; wr_data = 8'hEE;
      abort_go = 1'b0;
      expect_rd(8'h80, 8'h00, "R10 old data in busy");
      wait_busy("R7 ignore");
      commit_go = 1'b0; load_go = 1'b0; wr_vld = 1'b0;
      model[8'h80] = 8'hC1;
      model[8'h81] = 8'hC2;
      check("R7 counter unchanged", next_addr, 8'h82);
      commit(1'b0, "R7 valid cleared");
      verify_page(8, "R7 page 8");
      verify_page(9, "R7 page 9");

      // reads unaffected by write protect
      wp_in = 1'b1;
      expect_rd(8'h12, 8'hA5, "R10 read under protect");
      drain();
      wp_in = 1'b0;

      finish_run();
   end
endmodule